// File: doc/BRIEF.md
# Hardwired Control Sequencer

This block is the hardwired control unit of a small accumulator machine. It holds a memory address register, a memory buffer register, a program counter, an instruction register and one general register (R1). It walks every instruction through four phases: fetch, indirect, execute and interrupt. A 2-bit phase register names the current phase. A step counter marks timing steps t1 to t4 inside that phase. From the phase, the step and the opcode, a decoder raises one set of register-transfer strobes and memory strobes in each clock cycle. The registers perform those transfers in the same cycle.

The instruction word is 16 bits. Bits [15:12] hold the opcode, bit 11 is the indirect flag and bits [10:0] hold the address field. The machine knows three opcodes: ADD X adds the word at X to R1, ISZ X increments the word at X and skips the next instruction when the result is zero, and BSA X stores the return address at X and continues at X+1. The memory sits outside the block. It is word-addressed and synchronous: data for a read strobe arrives in the following cycle, and a write strobe stores the word at that clock edge. One level-sensitive interrupt request is serviced once after reset. Servicing stores PC at a fixed save address and jumps to a fixed routine address.

Top module: `uop_sequencer`

## Requirements
- R1: While rst_ni is low and before the first clock edge after its release, phase_o is 00, step_o is 0, pc_o equals RESET_PC (default 16), r1_o is 0 and int_en_o is 1.
- R2: Fetch lasts three steps. In t1 a read is issued at PC. In t2 MBR takes the returned word and PC increments. In t3 IR takes MBR.
- R3: The phase codes are fetch 00, indirect 01, execute 10 and interrupt 11. After fetch the phase is 01 when instruction bit 11 is set and 10 otherwise. After indirect it is 10. After interrupt it is 00.
- R4: Indirect lasts three steps. The word at the IR address field is read, and its bits [10:0] replace IR[10:0]. The instruction then executes as if that address had been given directly.
- R5: ADD (opcode 0) lasts three execute steps. It sets R1 to R1 plus the word at the effective address, modulo 2^16.
- R6: ISZ (opcode 1) lasts four execute steps. It writes the incremented word back to the effective address. When that word is zero, PC increments once more, so the next instruction is skipped.
- R7: BSA (opcode 2) lasts three execute steps. It stores the address of the following instruction at X and leaves PC at X+1.
- R8: Any other opcode gives a one-step execute phase that changes neither R1, memory nor the PC value left by fetch.
- R9: When irq_i is high, int_en_o is 1 and execute finishes, the interrupt phase follows. It lasts three steps, writes PC to SAVE_ADDR (default 0), sets PC to VEC_ADDR (default 1) and clears int_en_o.
- R10: Once int_en_o is 0, a high irq_i has no effect. Execute is followed by fetch until the next reset.
- R11: The step counter counts 0,1,2,... within a phase and is 0 in the first cycle of every new phase.
- R12: No step loads MBR from memory and IR from MBR together, and no step selects more than one source for MAR or for PC. ctrl_o bit 3 flags an MBR load from memory, and bit 9 flags an IR load from MBR.
- R13: A read strobe (mem_rd_o, also ctrl_o bit 12) presents its address in the same cycle, and MBR captures the data in the next step. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request, level |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the read strobe |
| mem_addr_o | output | 11 | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data (MBR) |
| phase_o | output | 2 | Current phase code |
| step_o | output | 2 | Current timing step, 0 for t1 |
| ctrl_o | output | 14 | Transfer strobes: 0 MAR<-PC, 1 MAR<-IR addr, 2 MAR<-save, 3 MBR<-mem, 4 MBR<-PC, 5 MBR+1, 6 PC+1, 7 PC<-IR addr, 8 PC<-vector, 9 IR<-MBR, 10 IR addr<-MBR, 11 R1 add, 12 read, 13 write |
| int_en_o | output | 1 | Interrupt enable |
| pc_o | output | 11 | Program counter |
| ir_o | output | 16 | Instruction register |
| mbr_o | output | 16 | Memory buffer register |
| r1_o | output | 16 | General register R1 |

## Verification
The assertions assume that the memory returns read data exactly one cycle after mem_rd_o. They also assume that irq_i is a level that holds steady across the last execute step. The bench meets both: its memory model registers each read on the strobe edge and applies writes at the same edge, and it changes irq_i only while reset is held. Instruction sequences that change control flow (skip, branch-and-save, interrupt) run as separate directed programs. The table program therefore always advances PC by one.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 11;
  localparam int OPC_W   = 4;
  localparam int STEP_W  = 2;
  localparam int IND_BIT = ADDR_W;
  localparam int OPC_LSB = ADDR_W + 1;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INT   = 2'b11
  } phase_e;

  localparam logic [OPC_W-1:0] OP_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OP_ISZ = 4'd1;
  localparam logic [OPC_W-1:0] OP_BSA = 4'd2;

  // first member is the MSB: bit 13 .. bit 0
  typedef struct packed {
    logic mem_wr;
    logic mem_rd;
    logic r1_add;
    logic ira_mbr;
    logic ir_mbr;
    logic pc_vec;
    logic pc_ir;
    logic pc_inc;
    logic mbr_inc;
    logic mbr_pc;
    logic mbr_mem;
    logic mar_sv;
    logic mar_ir;
    logic mar_pc;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/uop_phase_ctr.sv
module uop_phase_ctr
  import uop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              ind_i,
  input  logic              irq_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic              ie_o
);
  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q;
  logic              ie_q;
  logic              take_int;

  assign take_int = irq_i && ie_q;

  always_comb begin
    unique case (phase_q)
      PH_FETCH: phase_d = ind_i ? PH_IND : PH_EXEC;
      PH_IND:   phase_d = PH_EXEC;
      PH_EXEC:  phase_d = take_int ? PH_INT : PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
      ie_q    <= 1'b1;
    end else if (last_i) begin
      phase_q <= phase_d;
      step_q  <= '0;
      if (phase_q == PH_EXEC && take_int) ie_q <= 1'b0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign ie_o    = ie_q;

  assert_step_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (step_q == '0));

  assert_after_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH && last_i) |=> (phase_q == ($past(ind_i) ? PH_IND : PH_EXEC)));

  assert_after_int_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INT && last_i) |=> (phase_q == PH_FETCH));

  assert_int_clears_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INT) |-> !ie_q);

  assert_int_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INT && step_q == '0) |-> $past(ie_q));
endmodule

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic              mbr_zero_i,
  output ctrl_t             ctrl_o,
  output logic              last_o
);
  always_comb begin
    ctrl_o = '0;
    last_o = 1'b0;
    unique case (phase_i)
      PH_FETCH: begin
        unique case (step_i)
          2'd0:    begin ctrl_o.mar_pc = 1'b1; ctrl_o.mem_rd = 1'b1; end
          2'd1:    begin ctrl_o.mbr_mem = 1'b1; ctrl_o.pc_inc = 1'b1; end
          default: begin ctrl_o.ir_mbr = 1'b1; last_o = 1'b1; end
        endcase
      end
      PH_IND: begin
        unique case (step_i)
          2'd0:    begin ctrl_o.mar_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
          2'd1:    ctrl_o.mbr_mem = 1'b1;
          default: begin ctrl_o.ira_mbr = 1'b1; last_o = 1'b1; end
        endcase
      end
      PH_EXEC: begin
        if (opc_i == OP_ADD) begin
          unique case (step_i)
            2'd0:    begin ctrl_o.mar_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
            2'd1:    ctrl_o.mbr_mem = 1'b1;
            default: begin ctrl_o.r1_add = 1'b1; last_o = 1'b1; end
          endcase
        end else if (opc_i == OP_ISZ) begin
          unique case (step_i)
            2'd0: begin ctrl_o.mar_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
            2'd1: ctrl_o.mbr_mem = 1'b1;
            2'd2: ctrl_o.mbr_inc = 1'b1;
            default: begin
              ctrl_o.mem_wr = 1'b1;
              ctrl_o.pc_inc = mbr_zero_i;
              last_o        = 1'b1;
            end
          endcase
        end else if (opc_i == OP_BSA) begin
          unique case (step_i)
            2'd0:    begin ctrl_o.mar_ir = 1'b1; ctrl_o.mbr_pc = 1'b1; end
            2'd1:    begin ctrl_o.pc_ir = 1'b1; ctrl_o.mem_wr = 1'b1; end
            default: begin ctrl_o.pc_inc = 1'b1; last_o = 1'b1; end
          endcase
        end else begin
          last_o = 1'b1;
        end
      end
      default: begin
        unique case (step_i)
          2'd0:    ctrl_o.mbr_pc = 1'b1;
          2'd1:    begin ctrl_o.mar_sv = 1'b1; ctrl_o.pc_vec = 1'b1; end
          default: begin ctrl_o.mem_wr = 1'b1; last_o = 1'b1; end
        endcase
      end
    endcase
  end

  assert_mbr_ir_split_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.mbr_mem && ctrl_o.ir_mbr));

  assert_mar_one_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.mar_pc, ctrl_o.mar_ir, ctrl_o.mar_sv}));

  assert_pc_one_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.pc_inc, ctrl_o.pc_ir, ctrl_o.pc_vec}));

  assert_mbr_one_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.mbr_mem, ctrl_o.mbr_pc, ctrl_o.mbr_inc}));

  assert_rd_wr_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.mem_rd && ctrl_o.mem_wr));
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC  = 11'd16,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'd0,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 11'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mbr_zero_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] r1_o
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] mbr_q, ir_q, r1_q;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
      mbr_q <= '0;
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      r1_q  <= '0;
    end else begin
      if (ctrl_i.mar_pc)      mar_q <= pc_q;
      else if (ctrl_i.mar_ir) mar_q <= ir_addr;
      else if (ctrl_i.mar_sv) mar_q <= SAVE_ADDR;

      if (ctrl_i.mbr_mem)      mbr_q <= rdata_i;
      else if (ctrl_i.mbr_pc)  mbr_q <= {{PAD_W{1'b0}}, pc_q};
      else if (ctrl_i.mbr_inc) mbr_q <= mbr_q + 1'b1;

      if (ctrl_i.pc_inc)      pc_q <= pc_q + 1'b1;
      else if (ctrl_i.pc_ir)  pc_q <= ir_addr;
      else if (ctrl_i.pc_vec) pc_q <= VEC_ADDR;

      if (ctrl_i.ir_mbr)       ir_q <= mbr_q;
      else if (ctrl_i.ira_mbr) ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];

      if (ctrl_i.r1_add) r1_q <= r1_q + mbr_q;
    end
  end

  // a read goes out in the step that loads MAR; data lands in MBR next step
  always_comb begin
    if (ctrl_i.mar_pc)      addr_o = pc_q;
    else if (ctrl_i.mar_ir) addr_o = ir_addr;
    else                    addr_o = mar_q;
  end

  assign wdata_o    = mbr_q;
  assign mbr_zero_o = (mbr_q == '0);
  assign pc_o       = pc_q;
  assign ir_o       = ir_q;
  assign mbr_o      = mbr_q;
  assign r1_o       = r1_q;

  assert_mbr_after_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mbr_mem |-> $past(ctrl_i.mem_rd));

  assert_read_addr_in_mar_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mem_rd |=> (mar_q == $past(addr_o)));

  assert_r1_only_on_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_i.r1_add) |-> $stable(r1_q));
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC  = 11'd16,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'd0,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 11'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [1:0]        phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              int_en_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] r1_o
);
  phase_e            phase;
  logic [STEP_W-1:0] step;
  ctrl_t             ctrl;
  logic              last, mbr_zero;
  logic [DATA_W-1:0] ir_w, mbr_w;

  uop_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .last_i  (last),
    .ind_i   (mbr_w[IND_BIT]),  // IR is loaded from MBR in the same edge
    .irq_i   (irq_i),
    .phase_o (phase),
    .step_o  (step),
    .ie_o    (int_en_o)
  );

  uop_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .step_i     (step),
    .opc_i      (ir_w[DATA_W-1:OPC_LSB]),
    .mbr_zero_i (mbr_zero),
    .ctrl_o     (ctrl),
    .last_o     (last)
  );

  uop_datapath #(
    .RESET_PC  (RESET_PC),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .rdata_i    (mem_rdata_i),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .mbr_zero_o (mbr_zero),
    .pc_o       (pc_o),
    .ir_o       (ir_w),
    .mbr_o      (mbr_w),
    .r1_o       (r1_o)
  );

  assign mem_rd_o = ctrl.mem_rd;
  assign mem_wr_o = ctrl.mem_wr;
  assign phase_o  = phase;
  assign step_o   = step;
  assign ctrl_o   = ctrl;
  assign ir_o     = ir_w;
  assign mbr_o    = mbr_w;
endmodule

// File: tb/sim_uop_sequencer.sv
module sim_uop_sequencer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0;
  logic [15:0] mem_rdata;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [1:0]  phase;
  logic [1:0]  step;
  logic [13:0] ctrl;
  logic        int_en;
  logic [10:0] pc;
  logic [15:0] ir, mbr, r1;

  logic [15:0] mem [0:2047];
  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  uop_sequencer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .phase_o(phase), .step_o(step), .ctrl_o(ctrl),
    .int_en_o(int_en), .pc_o(pc), .ir_o(ir), .mbr_o(mbr), .r1_o(r1)
  );

  // memory model: read data one cycle after the strobe
  always @(posedge clk_i) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
  endtask

  function automatic logic [15:0] instr(input logic [3:0] op, input logic ind,
                                        input logic [10:0] a);
    return {op, ind, a};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // runs from one fetch t1 to the next, counting clocks
  task automatic run_one(output int cyc, output int int_cyc, output bit bad);
    logic [1:0] pp;
    cyc = 0; int_cyc = 0; bad = 1'b0; pp = phase;
    do begin
      @(negedge clk_i);
      cyc++;
      if (phase == 2'b11) int_cyc++;
      if (phase != pp && step != 2'd0) bad = 1'b1;
      pp = phase;
    end while (!(phase == 2'b00 && step == 2'd0) && cyc < 64);
  endtask

  // op, ind, addr field, operand, pointer target
  localparam int NV = 8;
  localparam logic [42:0] TBL [NV] = '{
    {4'd0,  1'b0, 11'd100, 16'h0005, 11'd0},
    {4'd0,  1'b0, 11'd101, 16'h1234, 11'd0},
    {4'd1,  1'b0, 11'd102, 16'h00FF, 11'd0},
    {4'd0,  1'b1, 11'd200, 16'h0100, 11'd300},
    {4'd7,  1'b0, 11'd0,   16'h0000, 11'd0},
    {4'd1,  1'b1, 11'd201, 16'h7FFF, 11'd301},
    {4'd0,  1'b0, 11'd103, 16'hFFF0, 11'd0},
    {4'd15, 1'b1, 11'd202, 16'h0000, 11'd302}
  };

  initial begin
    int cyc, icyc, expc;
    bit bad;
    logic [15:0] er1;
    logic [10:0] epc;

    // ---------------- reset state and fetch timing
    clear_mem();
    mem[16] = instr(4'd1, 1'b0, 11'd120);
    mem[17] = instr(4'd0, 1'b0, 11'd121);
    mem[18] = instr(4'd0, 1'b0, 11'd122);
    mem[120] = 16'hFFFF; mem[121] = 16'h0009; mem[122] = 16'h0003;
    @(negedge clk_i);
    chk(phase == 2'b00 && step == 2'd0, "R1 phase/step", {phase, step}, 0);
    chk(pc == 11'd16, "R1 pc", pc, 16);
    chk(r1 == 16'h0 && int_en == 1'b1, "R1 r1/int_en", {int_en, r1}, 17'h10000);
    do_reset();
    chk(mem_rd && mem_addr == 11'd16 && ctrl[12], "R13 read at PC in t1", mem_addr, 16);
    @(negedge clk_i);
    chk(step == 2'd1 && ctrl[3] && !ctrl[9] && !mem_rd && pc == 11'd16,
        "R2 t2 MBR load", {step, pc}, {2'd1, 11'd16});
    @(negedge clk_i);
    chk(step == 2'd2 && pc == 11'd17 && mbr == mem[16] && ctrl[9] && !ctrl[3],
        "R2 R12 t3 IR load", mbr, mem[16]);
    @(negedge clk_i);
    chk(ir == mem[16] && phase == 2'b10 && step == 2'd0, "R2 R3 enter execute", {phase, ir}, {2'b10, mem[16]});

    // ---------------- ISZ with skip
    run_one(cyc, icyc, bad);
    chk(cyc == 4, "R6 ISZ execute length", cyc, 4);
    chk(pc == 11'd18 && mem[120] == 16'h0000, "R6 skip on zero", {pc, mem[120]}, {11'd18, 16'h0});
    chk(!bad, "R11 step zero on phase change", bad, 0);
    run_one(cyc, icyc, bad);
    chk(r1 == 16'h0003, "R6 skipped instruction not run", r1, 3);

    // ---------------- table walk
    clear_mem();
    for (int i = 0; i < NV; i++) begin
      logic [42:0] e;
      e = TBL[i];
      mem[16 + i] = instr(e[42:39], e[38], e[37:27]);
      if (e[38]) begin
        mem[e[37:27]] = {5'b0, e[10:0]};
        mem[e[10:0]] = e[26:11];
      end else begin
        mem[e[37:27]] = e[26:11];
      end
    end
    do_reset();
    er1 = 16'h0;
    epc = 11'd16;
    for (int i = 0; i < NV; i++) begin
      logic [42:0] e;
      logic [10:0] ea;
      e = TBL[i];
      ea = e[38] ? e[10:0] : e[37:27];
      run_one(cyc, icyc, bad);
      epc = epc + 1'b1;
      expc = 3 + (e[38] ? 3 : 0) + (e[42:39] == 4'd0 ? 3 : e[42:39] == 4'd1 ? 4 : 1);
      if (e[42:39] == 4'd0) er1 = er1 + e[26:11];
      chk(cyc == expc, "R2 R5 R6 R8 instruction length", cyc, expc);
      chk(pc == epc, "R8 pc after instruction", pc, epc);
      chk(r1 == er1, "R5 accumulate", r1, er1);
      chk(!bad && icyc == 0, "R11 phase steps", {bad, icyc}, 0);
      if (e[42:39] == 4'd1)
        chk(mem[ea] == e[26:11] + 16'd1, "R6 ISZ writes increment", mem[ea], e[26:11] + 16'd1);
      if (e[38])
        chk(ir[10:0] == e[10:0], "R4 indirect address replaced", ir[10:0], e[10:0]);
    end

    // ---------------- BSA
    clear_mem();
    mem[16] = instr(4'd2, 1'b0, 11'd40);
    mem[41] = instr(4'd0, 1'b0, 11'd42);
    mem[42] = 16'h0007;
    do_reset();
    run_one(cyc, icyc, bad);
    chk(cyc == 6, "R7 BSA length", cyc, 6);
    chk(pc == 11'd41 && mem[40] == 16'd17, "R7 return saved, continue at X+1",
        {pc, mem[40]}, {11'd41, 16'd17});
    run_one(cyc, icyc, bad);
    chk(r1 == 16'h0007 && pc == 11'd42, "R7 runs from X+1", r1, 7);

    // ---------------- interrupt, taken once
    clear_mem();
    mem[16] = instr(4'd15, 1'b0, 11'd0);
    mem[1]  = instr(4'd15, 1'b0, 11'd0);
    mem[2]  = instr(4'd15, 1'b0, 11'd0);
    rst_ni = 1'b0;
    irq_i = 1'b1;
    do_reset();
    run_one(cyc, icyc, bad);
    chk(cyc == 7 && icyc == 3, "R9 interrupt phase length", {cyc, icyc}, {7, 3});
    chk(pc == 11'd1 && mem[0] == 16'd17, "R9 save PC, jump to vector", {pc, mem[0]}, {11'd1, 16'd17});
    chk(int_en == 1'b0 && !bad, "R9 R3 enable cleared, back to fetch", int_en, 0);
    run_one(cyc, icyc, bad);
    chk(cyc == 4 && icyc == 0 && pc == 11'd2, "R10 request ignored once disabled",
        {cyc, icyc, pc}, {4, 0, 11'd2});
    irq_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule